// File: doc/BRIEF.md
# Active-Column Zone Sparsifier

This block compresses one 64-pixel slice of the active column of a pixel submatrix into zone hits. The slice is cut into eight vertical zones of eight pixels each. Every zone with at least one fired pixel becomes one hit word. The word carries the column address, the 3-bit local zone address and the 8-bit occupancy pattern of that zone. All hits of a slice leave together in a single clock on an eight-lane bus. The non-empty zones are packed into the lowest lanes, and a count says how many lanes are valid.

The scan visits columns in time order, so all hits of one timestamp form a single sequence. When a column is offered with the sequence-start flag, the block first presents one header cycle that carries the timestamp and no hits. The hit group of that column follows in the next cycle.

A hold input lets the downstream stage refuse the group currently shown. While hold is high, the outputs stay frozen and the column input is not ready. A column is taken only on a clock edge where `colValid` and `colReady` are both high.

Top module: `zone_sparsifier`

## Requirements
- R1: After reset, `grpValid` and `hdrValid` are low, `hitCount` is 0, `hitBus` and `tsWord` are zero, and `colReady` is high.
- R2: Zone z covers pixels `colPixels[8z+7:8z]`. Its hit carries that byte as the pattern, with pixel 8z in pattern bit 0, and carries z as the 3-bit zone address.
- R3: A zone whose eight pixels are all zero produces no hit. Every lane at or above `hitCount` is all zeros.
- R4: Non-empty zones fill lanes 0, 1, 2, … in ascending zone order. `hitCount` equals the number of non-empty zones, from 0 to 8.
- R5: A hit word is 18 bits wide: {column[6:0], zone[2:0], pattern[7:0]}. Lane l occupies `hitBus[18l+17:18l]`.
- R6: A column accepted with `seqStart` high gives, one cycle later, a header cycle. In that cycle `hdrValid` is 1, `tsWord` equals the `tsIn` taken with the column, and `hitCount` is 0. The column's hit group follows in the next unheld cycle.
- R7: A column accepted with `seqStart` low shows its hit group with `grpValid` high one cycle after acceptance.
- R8: While `hold` is high during a header or a hit group, all outputs stay unchanged, `colReady` is low, and an offered column is not taken.
- R9: While a hit group is shown and `hold` is low, a new column can be accepted in that same cycle, so the block takes one column per clock. With no new column, the block returns to idle (`grpValid` low, `hitCount` 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| colValid | input | 1 | A slice of the active column is offered |
| seqStart | input | 1 | The offered column opens a new timestamp sequence |
| colPixels | input | 64 | Pixel hit flags of the slice, pixel 0 in bit 0 |
| colAddr | input | 7 | Column address within the submatrix |
| tsIn | input | 8 | Timestamp of the sequence |
| hold | input | 1 | Downstream cannot take the shown header or group |
| colReady | output | 1 | Column is accepted on this edge if offered |
| hdrValid | output | 1 | A timestamp header is shown |
| tsWord | output | 8 | Header timestamp, zero otherwise |
| grpValid | output | 1 | A hit group is shown |
| hitCount | output | 4 | Number of valid lanes, 0 to 8 |
| hitBus | output | 144 | Eight 18-bit hit lanes |

## Verification
The compaction is driven with a table of slices chosen so that wrong results can be told apart:
- An empty slice shows whether all-zero zones are suppressed.
- A full slice exercises the count of eight.
- Single hits in zone 0 and in zone 7 check the ends of the zone address range.
- A one-bit pattern placed at opposite ends of two zones exposes bit-order errors in the pattern.
- Alternating and nearly full occupancy show whether lanes are shifted or out of order.

Directed sequences then check:
- header-before-hits ordering;
- freezing under hold in both the header and the hit phase;
- back-to-back acceptance of columns.

// File: rtl/zsp_pkg.sv
`timescale 1ns/1ps
package zsp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_HITS = 2'd2
  } zspState_e;

  typedef struct packed {
    logic load;
    logic showHdr;
    logic showHits;
  } zspStrobe_t;

endpackage

// File: rtl/zsp_ctrl.sv
`timescale 1ns/1ps
module zsp_ctrl
  import zsp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       colValid,
  input  logic       seqStart,
  input  logic       hold,
  output logic       colReady,
  output logic       hdrValid,
  output logic       grpValid,
  output zspStrobe_t strb
);

  zspState_e state, stateNext;
  logic      accept;

  // a column may enter when nothing is shown, or when the shown group leaves now
  assign colReady = (state == ST_IDLE) || ((state == ST_HITS) && !hold);
  assign accept   = colValid && colReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept) stateNext = seqStart ? ST_HDR : ST_HITS;
      ST_HDR:  if (!hold) stateNext = ST_HITS;
      ST_HITS: begin
        if (!hold) begin
          if (accept) stateNext = seqStart ? ST_HDR : ST_HITS;
          else        stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign hdrValid      = (state == ST_HDR);
  assign grpValid      = (state == ST_HITS);
  assign strb.load     = accept;
  assign strb.showHdr  = hdrValid;
  assign strb.showHits = grpValid;

  // R6: a released header is always followed by the group of its column
  a_r6_hdr_then_group: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && !hold) |=> (grpValid && !hdrValid));

  // R8: held output stays put
  a_r8_hold_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    (hold && (hdrValid || grpValid)) |=> ($stable(hdrValid) && $stable(grpValid)));

  // header and group are never shown at once
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(hdrValid && grpValid));

endmodule

// File: rtl/zsp_datapath.sv
`timescale 1ns/1ps
module zsp_datapath
  import zsp_pkg::*;
#(
  parameter int ZONES  = 8,
  parameter int ZONE_W = 8,
  parameter int COL_W  = 7,
  parameter int TS_W   = 8,
  localparam int PIX_W   = ZONES * ZONE_W,
  localparam int ZADDR_W = $clog2(ZONES),
  localparam int HIT_W   = COL_W + ZADDR_W + ZONE_W,
  localparam int CNT_W   = $clog2(ZONES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  zspStrobe_t             strb,
  input  logic [PIX_W-1:0]       colPixels,
  input  logic [COL_W-1:0]       colAddr,
  input  logic [TS_W-1:0]        tsIn,
  output logic [ZONES*HIT_W-1:0] hitBus,
  output logic [CNT_W-1:0]       hitCount,
  output logic [TS_W-1:0]        tsWord
);

  logic [PIX_W-1:0]  pixReg;
  logic [COL_W-1:0]  colReg;
  logic [TS_W-1:0]   tsReg;

  logic [HIT_W-1:0]  laneArr [ZONES];
  logic [CNT_W-1:0]  cntComb;
  logic [ZONE_W-1:0] zonePat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixReg <= '0;
      colReg <= '0;
      tsReg  <= '0;
    end else if (strb.load) begin
      pixReg <= colPixels;
      colReg <= colAddr;
      tsReg  <= tsIn;
    end
  end

  // compaction: each non-empty zone goes to the next free lane
  always_comb begin
    cntComb = '0;
    zonePat = '0;
    for (int l = 0; l < ZONES; l++) laneArr[l] = '0;
    for (int z = 0; z < ZONES; z++) begin
      zonePat = pixReg[z*ZONE_W +: ZONE_W];
      if (zonePat != '0) begin
        laneArr[cntComb[ZADDR_W-1:0]] = {colReg, ZADDR_W'(z), zonePat};
        cntComb = cntComb + 1'b1;
      end
    end
  end

  genvar gl;
  generate
    for (gl = 0; gl < ZONES; gl++) begin : gLane
      assign hitBus[gl*HIT_W +: HIT_W] = strb.showHits ? laneArr[gl] : '0;

      // R3: lanes at or above the count carry nothing
      a_r3_empty_lane: assert property (@(posedge clk) disable iff (!rstN)
        (hitCount <= CNT_W'(gl)) |-> (hitBus[gl*HIT_W +: HIT_W] == '0));

      // R3: a valid lane never carries an empty pattern
      a_r3_nonempty_lane: assert property (@(posedge clk) disable iff (!rstN)
        (strb.showHits && hitCount > CNT_W'(gl)) |->
          (hitBus[gl*HIT_W +: ZONE_W] != '0));

      if (gl + 1 < ZONES) begin : gOrder
        // R4: zone addresses rise lane by lane
        a_r4_ascending: assert property (@(posedge clk) disable iff (!rstN)
          (hitCount > CNT_W'(gl + 1)) |->
            (hitBus[(gl+1)*HIT_W + ZONE_W +: ZADDR_W] > hitBus[gl*HIT_W + ZONE_W +: ZADDR_W]));
      end
    end
  endgenerate

  assign hitCount = strb.showHits ? cntComb : '0;
  assign tsWord   = strb.showHdr  ? tsReg   : '0;

  // R4: count bounded by the number of zones
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rstN)
    hitCount <= CNT_W'(ZONES));

  // R8: held data does not move
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strb.showHits && !strb.load) |=> $stable(pixReg) && $stable(colReg));

endmodule

// File: rtl/zone_sparsifier.sv
`timescale 1ns/1ps
module zone_sparsifier
  import zsp_pkg::*;
#(
  parameter int ZONES  = 8,
  parameter int ZONE_W = 8,
  parameter int COL_W  = 7,
  parameter int TS_W   = 8,
  localparam int PIX_W   = ZONES * ZONE_W,
  localparam int ZADDR_W = $clog2(ZONES),
  localparam int HIT_W   = COL_W + ZADDR_W + ZONE_W,
  localparam int CNT_W   = $clog2(ZONES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   colValid,
  input  logic                   seqStart,
  input  logic [PIX_W-1:0]       colPixels,
  input  logic [COL_W-1:0]       colAddr,
  input  logic [TS_W-1:0]        tsIn,
  input  logic                   hold,
  output logic                   colReady,
  output logic                   hdrValid,
  output logic [TS_W-1:0]        tsWord,
  output logic                   grpValid,
  output logic [CNT_W-1:0]       hitCount,
  output logic [ZONES*HIT_W-1:0] hitBus
);

  zspStrobe_t strb;

  zsp_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .colValid (colValid),
    .seqStart (seqStart),
    .hold     (hold),
    .colReady (colReady),
    .hdrValid (hdrValid),
    .grpValid (grpValid),
    .strb     (strb)
  );

  zsp_datapath #(
    .ZONES  (ZONES),
    .ZONE_W (ZONE_W),
    .COL_W  (COL_W),
    .TS_W   (TS_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .colPixels (colPixels),
    .colAddr   (colAddr),
    .tsIn      (tsIn),
    .hitBus    (hitBus),
    .hitCount  (hitCount),
    .tsWord    (tsWord)
  );

  // R9: without a group on show, the count reads zero
  a_r9_idle_count: assert property (@(posedge clk) disable iff (!rstN)
    !grpValid |-> (hitCount == '0));

  // R8: shown results are frozen under hold
  a_r8_frozen_bus: assert property (@(posedge clk) disable iff (!rstN)
    (hold && (grpValid || hdrValid)) |=> ($stable(hitBus) && $stable(tsWord) && $stable(hitCount)));

  // R8: no intake while held
  a_r8_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (hold && (grpValid || hdrValid)) |-> !colReady);

endmodule

// File: tb/tb_zone_sparsifier.sv
`timescale 1ns/1ps
module tb_zone_sparsifier;

  localparam int NV = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         colValid = 1'b0;
  logic         seqStart = 1'b0;
  logic [63:0]  colPixels = '0;
  logic [6:0]   colAddr = '0;
  logic [7:0]   tsIn = '0;
  logic         hold = 1'b0;
  logic         colReady, hdrValid, grpValid;
  logic [7:0]   tsWord;
  logic [3:0]   hitCount;
  logic [143:0] hitBus;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  zone_sparsifier dut (
    .clk(clk), .rstN(rstN), .colValid(colValid), .seqStart(seqStart),
    .colPixels(colPixels), .colAddr(colAddr), .tsIn(tsIn), .hold(hold),
    .colReady(colReady), .hdrValid(hdrValid), .tsWord(tsWord),
    .grpValid(grpValid), .hitCount(hitCount), .hitBus(hitBus)
  );

  // stimulus table: slice pattern, column, expected count
  localparam logic [63:0] PIX_TAB [NV] = '{
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000,
    64'h0100_0000_0000_0080, 64'h00AA_0000_5500_0000,
    64'h1200_3400_5600_7800, 64'h0001_0203_0405_0607
  };
  localparam logic [6:0] COL_TAB [NV] = '{7'd0, 7'd79, 7'd1, 7'd42, 7'd5, 7'd64, 7'd33, 7'd127};
  localparam logic [3:0] CNT_TAB [NV] = '{4'd0, 4'd8, 4'd1, 4'd1, 4'd2, 4'd2, 4'd4, 4'd7};

  // expected bus from R2-R5
  function automatic logic [143:0] expBus(input logic [63:0] pix, input logic [6:0] col);
    logic [143:0] b = '0;
    int lane = 0;
    for (int z = 0; z < 8; z++) begin
      if (pix[z*8 +: 8] != 8'h00) begin
        b[lane*18 +: 18] = {col, 3'(z), pix[z*8 +: 8]};
        lane++;
      end
    end
    return b;
  endfunction

  task automatic chk(input string req, input logic [143:0] act, input logic [143:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic offer(input logic [63:0] pix, input logic [6:0] col, input logic seq, input logic [7:0] ts);
    colValid = 1'b1; colPixels = pix; colAddr = col; seqStart = seq; tsIn = ts;
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nChk++; nErr++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 grpValid", 144'(grpValid), 144'(0));
    chk("R1 hdrValid", 144'(hdrValid), 144'(0));
    chk("R1 hitCount", 144'(hitCount), 144'(0));
    chk("R1 hitBus", hitBus, '0);
    chk("R1 colReady", 144'(colReady), 144'(1));
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      offer(PIX_TAB[i], COL_TAB[i], 1'b0, 8'h00);
      @(negedge clk);
      colValid = 1'b0;
      chk("R7 grpValid", 144'(grpValid), 144'(1));
      chk("R4 hitCount", 144'(hitCount), 144'(CNT_TAB[i]));
      chk("R2 R3 R5 hitBus", hitBus, expBus(PIX_TAB[i], COL_TAB[i]));
      @(negedge clk);
      chk("R9 idle return", 144'({grpValid, hitCount}), 144'(0));
    end

    // R6 header before hits
    offer(64'h0000_0000_00F0_0000, 7'd9, 1'b1, 8'hA5);
    @(negedge clk);
    colValid = 1'b0;
    chk("R6 hdrValid", 144'({hdrValid, grpValid}), 144'(2'b10));
    chk("R6 tsWord", 144'(tsWord), 144'(8'hA5));
    chk("R6 header count", 144'(hitCount), 144'(0));
    // R8 hold during header
    hold = 1'b1;
    offer(64'h1, 7'd3, 1'b0, 8'h00);
    @(negedge clk);
    chk("R8 header held", 144'({hdrValid, tsWord, colReady}), 144'({1'b1, 8'hA5, 1'b0}));
    @(negedge clk);
    chk("R8 header held 2", 144'({hdrValid, grpValid}), 144'(2'b10));
    colValid = 1'b0;
    hold = 1'b0;
    @(negedge clk);
    chk("R6 group after header", 144'({grpValid, hitCount}), 144'({1'b1, 4'd1}));
    chk("R6 group bus", hitBus, expBus(64'h0000_0000_00F0_0000, 7'd9));
    // R8 hold during group, offered column must wait
    hold = 1'b1;
    offer(64'hFF00_0000_0000_0000, 7'd77, 1'b0, 8'h00);
    @(negedge clk);
    chk("R8 colReady low", 144'(colReady), 144'(0));
    chk("R8 bus frozen", hitBus, expBus(64'h0000_0000_00F0_0000, 7'd9));
    @(negedge clk);
    chk("R8 bus frozen 2", hitBus, expBus(64'h0000_0000_00F0_0000, 7'd9));
    hold = 1'b0;
    @(negedge clk);
    colValid = 1'b0;
    chk("R8 waiting column taken", hitBus, expBus(64'hFF00_0000_0000_0000, 7'd77));
    @(negedge clk);

    // R9 back-to-back columns, one per clock
    offer(64'h0000_0000_0000_0003, 7'd10, 1'b0, 8'h00);
    @(negedge clk);
    chk("R9 first", hitBus, expBus(64'h3, 7'd10));
    offer(64'h0000_0300_0000_0000, 7'd11, 1'b0, 8'h00);
    @(negedge clk);
    chk("R9 second", hitBus, expBus(64'h0000_0300_0000_0000, 7'd11));
    offer(64'h0000_0000_0C00_0000, 7'd12, 1'b1, 8'h3C);
    @(negedge clk);
    colValid = 1'b0;
    chk("R6 header after group", 144'({hdrValid, tsWord}), 144'({1'b1, 8'h3C}));
    @(negedge clk);
    chk("R6 third group", hitBus, expBus(64'h0000_0000_0C00_0000, 7'd12));
    @(negedge clk);
    chk("R9 idle at end", 144'({grpValid, hdrValid, colReady}), 144'(3'b001));

    finishRun();
  end

endmodule